// File: doc/BRIEF.md
# Configurable Serial Character Transmitter

This block serializes characters onto a single output line. A producer offers one byte at a time on a valid/ready port. The byte lands in a one-entry holding register. A shift stage then sends it as an asynchronous frame: a low start bit, 5 to 8 data bits with the least significant bit first, an optional parity bit, and one, one-and-a-half or two high stop bits. The line rests high between frames.

A line-control byte selects the frame format, and a 16-bit divisor sets the bit rate. Both are captured when a frame starts. A break-control bit in the same byte is applied live and pulls the line low. Two status flags report progress. `hold_empty` means the holding register can take another byte. `tx_empty` means that register is empty and the shifter has also finished its last stop bit.

Back-pressure rules: `wr_ready` is high exactly when the holding register is empty. A byte transfers on a rising clock edge where `wr_valid` and `wr_ready` are both high. While the register is full, `wr_ready` stays low and the producer must hold its byte. If a byte is waiting when a frame's final stop bit ends, the next start bit follows with no idle gap.

Top module: `line_tx`

## Requirements
- R1: Reset state: `txd` is high, `hold_empty` and `tx_empty` are both high, and `wr_ready` is high.
- R2: A transfer (`wr_valid` and `wr_ready` high on a clock edge) drops `hold_empty` and `wr_ready` after that edge. From the idle state, the next edge moves the byte into the shifter and raises `hold_empty` again. While the register is full, `wr_ready` is low.
- R3: A frame begins with one low start bit, which is driven from the same cycle in which `hold_empty` rises. The data bits follow, least significant first. `line_ctl[1:0]` = 0, 1, 2, 3 selects 5, 6, 7 or 8 data bits, taken from the low bits of the byte.
- R4: Every start, data and parity bit lasts 16 × `divisor` clock cycles. A divisor of 0 acts as 1.
- R5: `line_ctl[3]` enables a parity bit after the data bits. With `line_ctl[5]` = 0, `line_ctl[4]` = 1 gives even parity and 0 gives odd parity, counted over the data bits sent. With `line_ctl[5]` = 1, the parity bit is the inverse of `line_ctl[4]`.
- R6: `line_ctl[2]` = 0 gives one stop bit, and 1 gives two stop bits. With 5-bit words, `line_ctl[2]` = 1 gives 1.5 stop bits (24 × `divisor` cycles).
- R7: While `line_ctl[6]` is 1, `txd` is 0, whether or not a frame is in progress. Framing continues underneath.
- R8: `tx_empty` is high only when `hold_empty` is high and no frame is in progress. It rises on the edge that ends the last stop bit.
- R9: When a byte waits in the holding register, the next start bit begins on the edge that ends the current stop period. Consecutive frame starts are therefore exactly one frame length apart.
- R10: The format bits `line_ctl[5:0]` and the divisor are captured when a frame starts. Changing them mid-frame does not affect that frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_valid | input | 1 | Producer offers a byte |
| wr_ready | output | 1 | Holding register can accept a byte |
| wr_data | input | 8 | Byte to send |
| line_ctl | input | 8 | Frame format and break control |
| divisor | input | 16 | Bit-rate divisor (bit time = 16 × divisor cycles) |
| hold_empty | output | 1 | Holding register empty |
| tx_empty | output | 1 | Holding register and shifter both empty |
| txd | output | 1 | Serial output line, idle high |

## Verification
A wrong sub-bit count or divisor latch changes the spacing of back-to-back start edges by at least one cycle. The spacing between successive falling edges is therefore measured exactly against the computed frame length. A wrong bit index or mask shows up one bit time after the start bit, as a wrong data or parity value sampled at mid-bit. A wrong stop count shows up either as a low line in the middle of the stop period or as a wrong frame spacing. A handshake or empty-flag fault appears within one or two cycles of the write, and `tx_empty` is checked on the exact cycle the last stop bit ends.

// File: rtl/line_tx_pkg.sv
package line_tx_pkg;

  localparam int unsigned CHAR_W = 8;
  localparam int unsigned IDX_W  = $clog2(CHAR_W);

  // line-control bit positions
  localparam int unsigned LC_STOP  = 2;
  localparam int unsigned LC_PEN   = 3;
  localparam int unsigned LC_EVEN  = 4;
  localparam int unsigned LC_STICK = 5;
  localparam int unsigned LC_BRK   = 6;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_START = 3'd1,
    ST_DATA  = 3'd2,
    ST_PAR   = 3'd3,
    ST_STOP  = 3'd4
  } tx_state_e;

  // keep only the bits of the selected word length
  function automatic logic [CHAR_W-1:0] word_mask(input logic [1:0] wls);
    return {CHAR_W{1'b1}} >> (3 - int'(wls));
  endfunction

  function automatic logic [IDX_W-1:0] last_index(input logic [1:0] wls);
    return IDX_W'(4 + int'(wls));
  endfunction

  function automatic logic parity_of(input logic [CHAR_W-1:0] bits,
                                     input logic [7:0] lc);
    logic odd_ones;
    odd_ones = ^bits;
    if (lc[LC_STICK]) return ~lc[LC_EVEN];
    return lc[LC_EVEN] ? odd_ones : ~odd_ones;
  endfunction

endpackage

// File: rtl/line_tx_baud.sv
module line_tx_baud #(
  parameter int unsigned DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [DIV_W-1:0] divisor,
  input  logic             run,
  output logic             tick
);

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] div_eff;

  assign div_eff = (divisor == '0) ? DIV_W'(1) : divisor;
  assign tick    = run && (cnt_q == div_q - DIV_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= DIV_W'(1);
      cnt_q <= '0;
    end else if (load) begin
      div_q <= div_eff;
      cnt_q <= '0;
    end else if (!run || tick) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + DIV_W'(1);
    end
  end

endmodule

// File: rtl/line_tx_hold.sv
module line_tx_hold #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [WIDTH-1:0] in_data,
  input  logic             take,
  output logic             full,
  output logic [WIDTH-1:0] data
);

  logic             full_q;
  logic [WIDTH-1:0] data_q;
  logic             accept;

  assign in_ready = !full_q;
  assign accept   = in_valid && !full_q;
  assign full     = full_q;
  assign data     = data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else begin
      if (accept) begin
        full_q <= 1'b1;
        data_q <= in_data;
      end else if (take) begin
        full_q <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/line_tx_fsm.sv
module line_tx_fsm
  import line_tx_pkg::*;
#(
  parameter int unsigned OVERSAMPLE = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hold_full,
  input  logic [CHAR_W-1:0] hold_data,
  input  logic [7:0]        line_ctl,
  input  logic              tick,
  output logic              take,
  output logic              busy,
  output logic              txd
);

  localparam int unsigned SUB_W = $clog2(2 * OVERSAMPLE);
  localparam logic [SUB_W-1:0] LAST_ONE  = SUB_W'(OVERSAMPLE - 1);
  localparam logic [SUB_W-1:0] LAST_ONEH = SUB_W'(OVERSAMPLE + OVERSAMPLE / 2 - 1);
  localparam logic [SUB_W-1:0] LAST_TWO  = SUB_W'(2 * OVERSAMPLE - 1);

  tx_state_e         state_q, state_d;
  logic [CHAR_W-1:0] shreg_q;
  logic [IDX_W-1:0]  idx_q;
  logic [SUB_W-1:0]  sub_q;
  logic [IDX_W-1:0]  last_idx_q;
  logic              par_en_q;
  logic              par_q;
  logic [SUB_W-1:0]  stop_last_q;

  logic [SUB_W-1:0]  seg_last;
  logic              seg_end;
  logic [CHAR_W-1:0] masked;
  logic [SUB_W-1:0]  stop_last_d;

  assign seg_last = (state_q == ST_STOP) ? stop_last_q : LAST_ONE;
  assign seg_end  = tick && (sub_q == seg_last);
  assign take     = hold_full &&
                    ((state_q == ST_IDLE) || (state_q == ST_STOP && seg_end));
  assign busy     = (state_q != ST_IDLE);
  assign masked   = hold_data & word_mask(line_ctl[1:0]);

  always_comb begin
    if (!line_ctl[LC_STOP])          stop_last_d = LAST_ONE;
    else if (line_ctl[1:0] == 2'd0)  stop_last_d = LAST_ONEH;
    else                             stop_last_d = LAST_TWO;
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (take) state_d = ST_START;
      ST_START: if (seg_end) state_d = ST_DATA;
      ST_DATA:  if (seg_end && idx_q == last_idx_q)
                  state_d = par_en_q ? ST_PAR : ST_STOP;
      ST_PAR:   if (seg_end) state_d = ST_STOP;
      ST_STOP:  if (seg_end) state_d = take ? ST_START : ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      shreg_q     <= '0;
      idx_q       <= '0;
      sub_q       <= '0;
      last_idx_q  <= '0;
      par_en_q    <= 1'b0;
      par_q       <= 1'b0;
      stop_last_q <= LAST_ONE;
    end else begin
      state_q <= state_d;
      if (take) begin
        shreg_q     <= masked;
        idx_q       <= '0;
        sub_q       <= '0;
        last_idx_q  <= last_index(line_ctl[1:0]);
        par_en_q    <= line_ctl[LC_PEN];
        par_q       <= parity_of(masked, line_ctl);
        stop_last_q <= stop_last_d;
      end else if (seg_end) begin
        sub_q <= '0;
        if (state_q == ST_DATA) begin
          shreg_q <= shreg_q >> 1;
          idx_q   <= idx_q + IDX_W'(1);
        end
      end else if (tick) begin
        sub_q <= sub_q + SUB_W'(1);
      end
    end
  end

  always_comb begin
    if (line_ctl[LC_BRK]) begin
      txd = 1'b0;
    end else begin
      unique case (state_q)
        ST_START: txd = 1'b0;
        ST_DATA:  txd = shreg_q[0];
        ST_PAR:   txd = par_q;
        default:  txd = 1'b1;
      endcase
    end
  end

endmodule

// File: rtl/line_tx.sv
module line_tx
  import line_tx_pkg::*;
#(
  parameter int unsigned DIV_W      = 16,
  parameter int unsigned OVERSAMPLE = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [CHAR_W-1:0] wr_data,
  input  logic [7:0]        line_ctl,
  input  logic [DIV_W-1:0]  divisor,
  output logic              hold_empty,
  output logic              tx_empty,
  output logic              txd
);

  logic              hold_full;
  logic [CHAR_W-1:0] hold_data;
  logic              take;
  logic              busy;
  logic              tick;

  line_tx_hold #(.WIDTH(CHAR_W)) u_hold (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (wr_valid),
    .in_ready (wr_ready),
    .in_data  (wr_data),
    .take     (take),
    .full     (hold_full),
    .data     (hold_data)
  );

  line_tx_baud #(.DIV_W(DIV_W)) u_baud (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (take),
    .divisor (divisor),
    .run     (busy),
    .tick    (tick)
  );

  line_tx_fsm #(.OVERSAMPLE(OVERSAMPLE)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .hold_full (hold_full),
    .hold_data (hold_data),
    .line_ctl  (line_ctl),
    .tick      (tick),
    .take      (take),
    .busy      (busy),
    .txd       (txd)
  );

  assign hold_empty = !hold_full;
  assign tx_empty   = !hold_full && !busy;

endmodule

// File: rtl/line_tx_checker.sv
module line_tx_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_valid,
  input logic       wr_ready,
  input logic [7:0] line_ctl,
  input logic       hold_empty,
  input logic       tx_empty,
  input logic       txd
);

  p_idle_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_empty && !line_ctl[6]) |-> txd);

  p_accept_fills_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready) |=> !hold_empty);

  p_full_stalls_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !hold_empty |-> !wr_ready);

  p_refill_starts_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(hold_empty) && !line_ctl[6]) |-> !txd);

  p_break_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    line_ctl[6] |-> !txd);

  p_txe_needs_thre_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_empty |-> hold_empty);

endmodule

bind line_tx line_tx_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_valid   (wr_valid),
  .wr_ready   (wr_ready),
  .line_ctl   (line_ctl),
  .hold_empty (hold_empty),
  .tx_empty   (tx_empty),
  .txd        (txd)
);

// File: tb/line_tx_tb.sv
module line_tx_tb;

  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic [7:0]  data;
    logic [7:0]  lc;
    logic [15:0] dv;
    bit          b2b;
  } item_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0;
  logic        wr_ready;
  logic [7:0]  wr_data = '0;
  logic [7:0]  lcr = 8'h03;
  logic [15:0] dvr = 16'd2;
  logic        hold_empty, tx_empty, txd;

  int    cyc = 0;
  int    n_checks = 0;
  int    n_fail = 0;
  item_t sb[$];

  always #(CLK_PERIOD / 2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  line_tx u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_valid   (wr_valid),
    .wr_ready   (wr_ready),
    .wr_data    (wr_data),
    .line_ctl   (lcr),
    .divisor    (dvr),
    .hold_empty (hold_empty),
    .tx_empty   (tx_empty),
    .txd        (txd)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic int bit_cycles(input logic [15:0] d);
    return 16 * ((d == 0) ? 1 : int'(d));
  endfunction

  function automatic int frame_len(input item_t it);
    int dv, b, n, st;
    dv = (it.dv == 0) ? 1 : int'(it.dv);
    b  = 16 * dv;
    n  = 5 + int'(it.lc[1:0]);
    if (!it.lc[2])           st = b;
    else if (it.lc[1:0] == 0) st = 24 * dv;
    else                     st = 2 * b;
    return b * (1 + n + (it.lc[3] ? 1 : 0)) + st;
  endfunction

  function automatic logic exp_parity(input item_t it);
    int ones;
    ones = $countones(it.data & (8'hFF >> (3 - int'(it.lc[1:0]))));
    if (it.lc[5]) return ~it.lc[4];
    return it.lc[4] ? logic'(ones % 2) : logic'(1 - ones % 2);
  endfunction

  // driver: queue the expected frame, then hand the byte over
  task automatic send(input logic [7:0] d, input bit b2b, output int acc);
    item_t it;
    it.data = d; it.lc = lcr; it.dv = dvr; it.b2b = b2b;
    sb.push_back(it);
    @(negedge clk);
    while (!wr_ready) @(negedge clk);
    wr_valid = 1'b1;
    wr_data  = d;
    @(posedge clk);
    @(negedge clk);
    wr_valid = 1'b0;
    acc = cyc;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (!(tx_empty && sb.size() == 0)) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  // monitor: decode each frame at mid-bit and compare with the scoreboard
  initial begin
    logic prev;
    int   last_fall;
    int   last_len;
    prev = 1'b1;
    last_fall = 0;
    last_len = 0;
    forever begin
      @(negedge clk);
      if (rst_n && !lcr[6] && prev && !txd) begin
        item_t it;
        int fall, b, n;
        logic [7:0] got;
        fall = cyc;
        if (sb.size() == 0) begin
          check(1'b0, "R3", "unexpected frame", 0, 1);
        end else begin
          it = sb.pop_front();
          b = bit_cycles(it.dv);
          n = 5 + int'(it.lc[1:0]);
          if (it.b2b)
            check(fall - last_fall == last_len, "R9/R4/R6", "start spacing",
                  fall - last_fall, last_len);
          repeat (b / 2) @(negedge clk);
          check(txd == 1'b0, "R3", "start bit", txd, 0);
          got = '0;
          for (int i = 0; i < n; i++) begin
            repeat (b) @(negedge clk);
            got[i] = txd;
          end
          check(got == (it.data & (8'hFF >> (8 - n))), "R3/R10", "data bits",
                got, it.data & (8'hFF >> (8 - n)));
          if (it.lc[3]) begin
            repeat (b) @(negedge clk);
            check(txd == exp_parity(it), "R5", "parity bit", txd, exp_parity(it));
          end
          repeat (b) @(negedge clk);
          check(txd == 1'b1, "R6", "first stop bit", txd, 1);
          if (it.lc[2] && it.lc[1:0] != 0) begin
            repeat (b) @(negedge clk);
            check(txd == 1'b1, "R6", "second stop bit", txd, 1);
          end
          last_fall = fall;
          last_len = frame_len(it);
        end
      end
      prev = txd;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog", "run did not finish", 0, 1);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    int w;
    int len;
    item_t tmp;
    repeat (4) @(negedge clk);
    // R1: reset state
    check(txd == 1'b1, "R1", "txd in reset", txd, 1);
    check(hold_empty && tx_empty && wr_ready, "R1", "empty flags in reset",
          {hold_empty, tx_empty, wr_ready}, 3'b111);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(txd && hold_empty && tx_empty, "R1", "state after reset",
          {txd, hold_empty, tx_empty}, 3'b111);

    // R2, R8: single frame from idle, 8N1, divisor 2
    lcr = 8'h03; dvr = 16'd2;
    send(8'hA5, 1'b0, w);
    tmp.data = 8'hA5; tmp.lc = lcr; tmp.dv = dvr; tmp.b2b = 1'b0;
    len = frame_len(tmp);
    check(!hold_empty && !wr_ready, "R2", "full after accept",
          {hold_empty, wr_ready}, 0);
    @(negedge clk);
    check(hold_empty && wr_ready, "R2", "refilled shifter empties holding",
          {hold_empty, wr_ready}, 3);
    check(txd == 1'b0, "R3", "start coincides with empty", txd, 0);
    check(!tx_empty, "R8", "tx_empty low while shifting", tx_empty, 0);
    while (cyc < w + len) @(negedge clk);
    check(!tx_empty, "R8", "tx_empty low in last stop cycle", tx_empty, 0);
    @(negedge clk);
    check(tx_empty, "R8", "tx_empty high after stop", tx_empty, 1);
    wait_idle();

    // R5: parity modes
    lcr = 8'h0A; send(8'h5B, 1'b0, w); wait_idle();  // 7 bits odd
    lcr = 8'h19; send(8'h19, 1'b0, w); wait_idle();  // 6 bits even
    lcr = 8'h3B; send(8'hF0, 1'b0, w); wait_idle();  // stick, bit 0
    lcr = 8'h2B; send(8'h0F, 1'b0, w); wait_idle();  // stick, bit 1

    // R6, R9, R2: back-to-back with two stop bits
    lcr = 8'h07;
    send(8'h3C, 1'b0, w);
    send(8'hC3, 1'b1, w);
    send(8'h96, 1'b1, w);
    check(!wr_ready, "R2", "ready low while holding full", wr_ready, 0);
    wait_idle();

    // R6: 5-bit words, 1.5 stop bits
    lcr = 8'h04;
    send(8'h15, 1'b0, w);
    send(8'h0A, 1'b1, w);
    send(8'h1F, 1'b1, w);
    wait_idle();
    // 5-bit words, one stop bit, with parity
    lcr = 8'h08;
    send(8'h11, 1'b0, w);
    send(8'h0E, 1'b1, w);
    wait_idle();

    // R4: divisor 0 acts as 1, and divisor 3
    lcr = 8'h03; dvr = 16'd0;
    send(8'h3C, 1'b0, w);
    send(8'hE1, 1'b1, w);
    wait_idle();
    dvr = 16'd3;
    send(8'h7E, 1'b0, w);
    send(8'h81, 1'b1, w);
    wait_idle();

    // R10: format and divisor change mid-frame
    lcr = 8'h03; dvr = 16'd2;
    send(8'h81, 1'b0, w);
    repeat (20) @(negedge clk);
    lcr = 8'h1D; dvr = 16'd5;
    wait_idle();
    lcr = 8'h03; dvr = 16'd2;

    // R7: break holds the line low
    lcr = 8'h43;
    @(negedge clk);
    check(txd == 1'b0, "R7", "break forces line low", txd, 0);
    check(tx_empty, "R7", "break leaves transmitter empty", tx_empty, 1);
    repeat (5) @(negedge clk);
    check(txd == 1'b0, "R7", "break still low", txd, 0);
    lcr = 8'h03;
    @(negedge clk);
    check(txd == 1'b1, "R7", "line high after break", txd, 1);

    // final frame after break
    send(8'h55, 1'b0, w);
    wait_idle();
    check(sb.size() == 0, "R3", "all frames observed", sb.size(), 0);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule